// File: doc/BRIEF.md
# Pixel Format Packer with Alpha Control

This block sits at the end of a pixel pipeline, where pixels are written to memory. Each cycle it takes one pixel with 8 bits for each of alpha, red, green and blue. It converts that pixel into one of twelve memory pixel layouts, from 16 to 32 bits per pixel, and turns the result into 32-bit little-endian write words with a strobe for each byte. Sub-word pixels are packed densely. A 16-bit pixel fills half a word. A 24-bit pixel may straddle two words. The first pixel of a line always starts at byte 0 of a word.

The same static configuration applies to every pixel. It consists of a format code, an alpha-store enable, an alpha-invert bit and a four-bit byte-enable mask. Alpha is either stored (optionally complemented) or replaced by a constant that the invert bit selects. The mask gates every byte lane of every word that is written. The source marks the last pixel of a line. If bytes are still pending after that pixel, the block spends one extra cycle writing them out as a partial word, and it holds off input during that cycle.

The packer is a small state machine. States: `ST_EMPTY` (no bytes pending), `ST_HOLD1`/`ST_HOLD2`/`ST_HOLD3` (one to three bytes pending, mid-line) and `ST_FLUSH1`/`ST_FLUSH2`/`ST_FLUSH3` (one to three bytes to emit as a partial word). Transitions:
- An accepted pixel moves from `ST_EMPTY` or `ST_HOLDn` to the state named by the bytes left over after any full word is emitted. The target is `ST_HOLDn` mid-line, `ST_FLUSHn` at line end with leftovers, or `ST_EMPTY` when nothing is left.
- Every `ST_FLUSHn` returns to `ST_EMPTY` after one cycle.
- A cycle with no accepted pixel stays put.

Top module: `pix_packer`

## Requirements
- R1: Channel order follows the format code, listed from the most significant field of the pixel down to bit 0. The codes are:
  - 0 = A,B,G,R at 4 bits each
  - 1 = A,R,G,B at 4 bits each
  - 2 = B,G,R,A at 4 bits each
  - 3 = R,G,B,A at 4 bits each
  - 6 = B,G,R at 5/6/5 bits
  - 7 = R,G,B at 5/6/5 bits
  - 8 = B,G,R at 8 bits each
  - 9 = R,G,B at 8 bits each
  - 12 = A,B,G,R at 8 bits each
  - 13 = A,R,G,B at 8 bits each
  - 14 = B,G,R,A at 8 bits each
  - 15 = R,G,B,A at 8 bits each
- R2: A field narrower than 8 bits keeps the most significant bits of its input channel.
- R3: With alpha store enabled, the alpha field holds the input alpha. When the invert bit is also set, it holds the bitwise complement of the input alpha.
- R4: With alpha store disabled, every bit of the alpha field equals the complement of the invert bit (all ones when invert is 0, all zeros when invert is 1).
- R5: 16-bit pixels pack two to a word. The earlier pixel of the pair occupies bits 15:0.
- R6: 24-bit pixels pack four to three words as a continuous little-endian byte stream. Each pixel contributes its bits 7:0 first.
- R7: A 32-bit pixel fills one whole word by itself.
- R8: A full word is written with a strobe equal to the byte-enable mask, where bit i gates byte i (bits 8i+7:8i).
- R9: After the last pixel of a line, any 1 to 3 leftover bytes are written one cycle later as a partial word. Its strobe has ones only on the low lanes that hold those bytes, ANDed with the mask. `pix_ready` is low during that one cycle, and a pixel offered then is not taken.
- R10: A pixel offered with an unlisted code (4, 5, 10, 11) causes no write and sets `fmt_err`. `fmt_err` stays set until reset.
- R11: A word appears on the write port in the cycle after the edge that accepts the pixel completing it. Cycles without a completed word have `wr_valid` low and a zero strobe.
- R12: After reset there is no write, `fmt_err` is 0, `pix_ready` is 1 and no bytes are pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_fmt | input | 4 | Output pixel format code |
| cfg_alpha_en | input | 1 | Store the pixel alpha instead of a constant |
| cfg_alpha_inv | input | 1 | Complement stored alpha, or select the fill constant |
| cfg_byte_en | input | 4 | Byte-lane write mask |
| pix_valid | input | 1 | Input pixel present |
| pix_argb | input | 32 | Input pixel, alpha in 31:24, red 23:16, green 15:8, blue 7:0 |
| pix_eol | input | 1 | Input pixel is the last of its line |
| pix_ready | output | 1 | Low during a partial-word flush cycle |
| wr_valid | output | 1 | Write word present |
| wr_data | output | 32 | Packed write word |
| wr_strb | output | 4 | Byte strobes of the write word |
| fmt_err | output | 1 | Sticky unlisted-format flag |

## Verification
Every write word is registered. It is due on the first edge after the edge that accepts its completing pixel. A partial flush word is due exactly one edge later still, and `fmt_err` rises on the same edge that takes the bad pixel. The bench drives each pixel half a period before an edge and reads the ports half a period after it. This gives a fixed point to compare the output state after each edge. Each expected word is therefore checked in one specific cycle, and for pixels that must not produce a write, the cycles on both sides are checked as well.

// File: rtl/pxp_pkg.sv
package pxp_pkg;
    localparam int CH_W       = 8;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = CH_W * WORD_BYTES;
    localparam int HOLD_W     = CH_W * (WORD_BYTES - 1);
    localparam int CNT_W      = $clog2(2 * WORD_BYTES);
    localparam int FMT_W      = 4;

    typedef struct packed {
        logic [CH_W-1:0] a;
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } argb_t;

    typedef enum logic [2:0] {
        ST_EMPTY,
        ST_HOLD1,
        ST_HOLD2,
        ST_HOLD3,
        ST_FLUSH1,
        ST_FLUSH2,
        ST_FLUSH3
    } pack_state_e;

    localparam logic [FMT_W-1:0] FMT_ABGR4444 = 4'd0;
    localparam logic [FMT_W-1:0] FMT_ARGB4444 = 4'd1;
    localparam logic [FMT_W-1:0] FMT_BGRA4444 = 4'd2;
    localparam logic [FMT_W-1:0] FMT_RGBA4444 = 4'd3;
    localparam logic [FMT_W-1:0] FMT_BGR565   = 4'd6;
    localparam logic [FMT_W-1:0] FMT_RGB565   = 4'd7;
    localparam logic [FMT_W-1:0] FMT_BGR888   = 4'd8;
    localparam logic [FMT_W-1:0] FMT_RGB888   = 4'd9;
    localparam logic [FMT_W-1:0] FMT_ABGR8888 = 4'd12;
    localparam logic [FMT_W-1:0] FMT_ARGB8888 = 4'd13;
    localparam logic [FMT_W-1:0] FMT_BGRA8888 = 4'd14;
    localparam logic [FMT_W-1:0] FMT_RGBA8888 = 4'd15;
endpackage

// File: rtl/pxp_convert.sv
// Maps one ARGB pixel to its memory layout, right-aligned, with its byte size.
module pxp_convert
    import pxp_pkg::*;
(
    input  logic [FMT_W-1:0]  fmt,
    input  logic              alpha_en,
    input  logic              alpha_inv,
    input  argb_t             pix,
    output logic [WORD_W-1:0] value,
    output logic [CNT_W-1:0]  nbytes,
    output logic              bad
);
    localparam int H = CH_W - 1;

    logic [CH_W-1:0] a8;

    // Stored alpha (optionally complemented) or the constant fill.
    assign a8 = alpha_en ? (pix.a ^ {CH_W{alpha_inv}}) : {CH_W{~alpha_inv}};

    always_comb begin
        value  = '0;
        nbytes = '0;
        bad    = 1'b0;
        case (fmt)
            FMT_ABGR4444: begin
                value[15:0] = {a8[H -: 4], pix.b[H -: 4], pix.g[H -: 4], pix.r[H -: 4]};
                nbytes = CNT_W'(2);
            end
            FMT_ARGB4444: begin
                value[15:0] = {a8[H -: 4], pix.r[H -: 4], pix.g[H -: 4], pix.b[H -: 4]};
                nbytes = CNT_W'(2);
            end
            FMT_BGRA4444: begin
                value[15:0] = {pix.b[H -: 4], pix.g[H -: 4], pix.r[H -: 4], a8[H -: 4]};
                nbytes = CNT_W'(2);
            end
            FMT_RGBA4444: begin
                value[15:0] = {pix.r[H -: 4], pix.g[H -: 4], pix.b[H -: 4], a8[H -: 4]};
                nbytes = CNT_W'(2);
            end
            FMT_BGR565: begin
                value[15:0] = {pix.b[H -: 5], pix.g[H -: 6], pix.r[H -: 5]};
                nbytes = CNT_W'(2);
            end
            FMT_RGB565: begin
                value[15:0] = {pix.r[H -: 5], pix.g[H -: 6], pix.b[H -: 5]};
                nbytes = CNT_W'(2);
            end
            FMT_BGR888: begin
                value[23:0] = {pix.b, pix.g, pix.r};
                nbytes = CNT_W'(3);
            end
            FMT_RGB888: begin
                value[23:0] = {pix.r, pix.g, pix.b};
                nbytes = CNT_W'(3);
            end
            FMT_ABGR8888: begin
                value  = {a8, pix.b, pix.g, pix.r};
                nbytes = CNT_W'(4);
            end
            FMT_ARGB8888: begin
                value  = {a8, pix.r, pix.g, pix.b};
                nbytes = CNT_W'(4);
            end
            FMT_BGRA8888: begin
                value  = {pix.b, pix.g, pix.r, a8};
                nbytes = CNT_W'(4);
            end
            FMT_RGBA8888: begin
                value  = {pix.r, pix.g, pix.b, a8};
                nbytes = CNT_W'(4);
            end
            default: bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/pxp_strobe.sv
// Lane strobes: the low cnt lanes, gated by the byte-enable mask.
module pxp_strobe
    import pxp_pkg::*;
(
    input  logic [CNT_W-1:0]      cnt,
    input  logic [WORD_BYTES-1:0] byte_en,
    output logic [WORD_BYTES-1:0] strb
);
    for (genvar i = 0; i < WORD_BYTES; i++) begin : g_lane
        assign strb[i] = byte_en[i] & (CNT_W'(i) < cnt);
    end
endmodule

// File: rtl/pix_packer.sv
module pix_packer
    import pxp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [FMT_W-1:0]      cfg_fmt,
    input  logic                  cfg_alpha_en,
    input  logic                  cfg_alpha_inv,
    input  logic [WORD_BYTES-1:0] cfg_byte_en,
    input  logic                  pix_valid,
    input  logic [WORD_W-1:0]     pix_argb,
    input  logic                  pix_eol,
    output logic                  pix_ready,
    output logic                  wr_valid,
    output logic [WORD_W-1:0]     wr_data,
    output logic [WORD_BYTES-1:0] wr_strb,
    output logic                  fmt_err
);
    localparam int MERGE_W = WORD_W + HOLD_W;

    pack_state_e           state_q, state_d;
    logic [HOLD_W-1:0]     hold_q, hold_d;
    logic [WORD_W-1:0]     value, wd_d;
    logic [CNT_W-1:0]      nbytes, held, total, rem, lane_cnt;
    logic [MERGE_W-1:0]    merged;
    logic [WORD_BYTES-1:0] strb_w;
    logic                  bad, flushing, accept, full, wv_d;

    pxp_convert u_conv (
        .fmt       (cfg_fmt),
        .alpha_en  (cfg_alpha_en),
        .alpha_inv (cfg_alpha_inv),
        .pix       (argb_t'(pix_argb)),
        .value     (value),
        .nbytes    (nbytes),
        .bad       (bad)
    );

    pxp_strobe u_strb (
        .cnt     (lane_cnt),
        .byte_en (cfg_byte_en),
        .strb    (strb_w)
    );

    function automatic pack_state_e next_of(input logic [CNT_W-1:0] left, input logic eol);
        unique case (left)
            CNT_W'(1): next_of = eol ? ST_FLUSH1 : ST_HOLD1;
            CNT_W'(2): next_of = eol ? ST_FLUSH2 : ST_HOLD2;
            CNT_W'(3): next_of = eol ? ST_FLUSH3 : ST_HOLD3;
            default:   next_of = ST_EMPTY;
        endcase
    endfunction

    always_comb begin
        held     = '0;
        flushing = 1'b0;
        unique case (state_q)
            ST_EMPTY:  held = CNT_W'(0);
            ST_HOLD1:  held = CNT_W'(1);
            ST_HOLD2:  held = CNT_W'(2);
            ST_HOLD3:  held = CNT_W'(3);
            ST_FLUSH1: begin held = CNT_W'(1); flushing = 1'b1; end
            ST_FLUSH2: begin held = CNT_W'(2); flushing = 1'b1; end
            ST_FLUSH3: begin held = CNT_W'(3); flushing = 1'b1; end
            default:   held = CNT_W'(0);
        endcase
    end

    assign pix_ready = ~flushing;
    assign accept    = pix_valid & pix_ready & ~bad;
    assign total     = held + nbytes;
    assign full      = total >= CNT_W'(WORD_BYTES);
    assign rem       = full ? total - CNT_W'(WORD_BYTES) : total;
    assign merged    = ({{HOLD_W{1'b0}}, value} << (held * CH_W)) | {{WORD_W{1'b0}}, hold_q};
    assign lane_cnt  = flushing ? held : CNT_W'(WORD_BYTES);

    // Next state, pending bytes and the word to register.
    always_comb begin
        state_d = state_q;
        hold_d  = hold_q;
        wv_d    = 1'b0;
        wd_d    = '0;
        unique case (state_q)
            ST_FLUSH1, ST_FLUSH2, ST_FLUSH3: begin
                wv_d    = 1'b1;
                wd_d    = {{CH_W{1'b0}}, hold_q};
                hold_d  = '0;
                state_d = ST_EMPTY;
            end
            default: begin
                if (accept) begin
                    hold_d  = full ? merged[WORD_W +: HOLD_W] : merged[HOLD_W-1:0];
                    wv_d    = full;
                    wd_d    = full ? merged[WORD_W-1:0] : '0;
                    state_d = next_of(rem, pix_eol);
                end
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            hold_q  <= hold_d;
        end
    end

    // Output registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_data  <= '0;
            wr_strb  <= '0;
            fmt_err  <= 1'b0;
        end else begin
            wr_valid <= wv_d;
            wr_data  <= wd_d;
            wr_strb  <= wv_d ? strb_w : '0;
            fmt_err  <= fmt_err | (pix_valid & pix_ready & bad);
        end
    end
endmodule

// File: rtl/pxp_checker.sv
module pxp_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       pix_valid,
    input logic       pix_ready,
    input logic       wr_valid,
    input logic [3:0] wr_strb,
    input logic [3:0] cfg_byte_en,
    input logic       fmt_err
);
    assert_flush_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_ready |=> pix_ready);

    assert_flush_writes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_ready |=> wr_valid);

    assert_flush_partial_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_ready |=> ($countones(wr_strb) <= 3));

    assert_strb_in_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ((wr_strb & ~$past(cfg_byte_en)) == 4'h0));

    assert_idle_no_strb_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |-> (wr_strb == 4'h0));

    assert_write_has_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> ($past(pix_valid) || !$past(pix_ready)));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fmt_err |=> fmt_err);

    assert_err_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fmt_err) |-> !wr_valid);
endmodule

bind pix_packer pxp_checker u_pxp_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_valid   (pix_valid),
    .pix_ready   (pix_ready),
    .wr_valid    (wr_valid),
    .wr_strb     (wr_strb),
    .cfg_byte_en (cfg_byte_en),
    .fmt_err     (fmt_err)
);

// File: tb/test_pix_packer.sv
module test_pix_packer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_fmt = 4'd13;
    logic        cfg_alpha_en = 1'b1;
    logic        cfg_alpha_inv = 1'b0;
    logic [3:0]  cfg_byte_en = 4'hF;
    logic        pix_valid = 1'b0;
    logic [31:0] pix_argb = '0;
    logic        pix_eol = 1'b0;
    logic        pix_ready, wr_valid, fmt_err;
    logic [31:0] wr_data;
    logic [3:0]  wr_strb;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pix_packer i_pix_packer (
        .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_alpha_en(cfg_alpha_en),
        .cfg_alpha_inv(cfg_alpha_inv), .cfg_byte_en(cfg_byte_en), .pix_valid(pix_valid),
        .pix_argb(pix_argb), .pix_eol(pix_eol), .pix_ready(pix_ready), .wr_valid(wr_valid),
        .wr_data(wr_data), .wr_strb(wr_strb), .fmt_err(fmt_err)
    );

    // {format, alpha_en, alpha_inv, pixel, expected right-aligned pixel value}
    localparam int NV = 14;
    localparam logic [69:0] VEC [NV] = '{
        {4'd13, 1'b1, 1'b0, 32'hC3965A3C, 32'hC3965A3C},
        {4'd12, 1'b1, 1'b0, 32'hC3965A3C, 32'hC33C5A96},
        {4'd14, 1'b1, 1'b0, 32'hC3965A3C, 32'h3C5A96C3},
        {4'd15, 1'b0, 1'b0, 32'hC3965A3C, 32'h965A3CFF},
        {4'd13, 1'b0, 1'b1, 32'hC3965A3C, 32'h00965A3C},
        {4'd13, 1'b1, 1'b1, 32'hC3965A3C, 32'h3C965A3C},
        {4'd1,  1'b1, 1'b0, 32'hC3965A3C, 32'h0000C953},
        {4'd0,  1'b0, 1'b0, 32'hC3965A3C, 32'h0000F359},
        {4'd3,  1'b1, 1'b1, 32'hC3965A3C, 32'h00009533},
        {4'd2,  1'b1, 1'b0, 32'hC3965A3C, 32'h0000359C},
        {4'd7,  1'b1, 1'b0, 32'hC3965A3C, 32'h000092C7},
        {4'd6,  1'b1, 1'b0, 32'hC3965A3C, 32'h00003AD2},
        {4'd9,  1'b1, 1'b0, 32'hC3965A3C, 32'h00965A3C},
        {4'd8,  1'b1, 1'b0, 32'hC3965A3C, 32'h003C5A96}
    };

    function automatic int bytes_of(input logic [3:0] f);
        if (f <= 4'd3 || f == 4'd6 || f == 4'd7) return 2;
        if (f == 4'd8 || f == 4'd9) return 3;
        if (f >= 4'd12) return 4;
        return 0;
    endfunction

    function automatic logic [31:0] lane_mask(input logic [3:0] s);
        return {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic [31:0] px, input logic eol);
        pix_valid = 1'b1;
        pix_argb  = px;
        pix_eol   = eol;
        step();
        pix_valid = 1'b0;
        pix_eol   = 1'b0;
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        #3000000;
        n_errors++;
        $display("FAIL watchdog actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 reset outputs", {29'b0, wr_valid, fmt_err, pix_ready}, 32'h1);
        rst_n = 1'b1;
        step();
        chk("R12 idle after reset", {28'b0, wr_strb}, 32'h0);

        // R1 R2 R3 R4 R7 R9: table of single-pixel lines
        for (int i = 0; i < NV; i++) begin
            logic [69:0] v = VEC[i];
            int sz;
            cfg_fmt = v[69:66]; cfg_alpha_en = v[65]; cfg_alpha_inv = v[64];
            sz = bytes_of(v[69:66]);
            drive(v[63:32], 1'b1);
            if (sz == 4) begin
                chk("R1/R3/R4/R7 word valid+strb", {27'b0, wr_valid, wr_strb}, 32'h1F);
                chk("R1/R3/R4/R7 word data", wr_data, v[31:0]);
            end else begin
                chk("R11 no word before flush", {31'b0, wr_valid}, 32'h0);
                step();
                chk("R9 flush valid+strb", {27'b0, wr_valid, wr_strb},
                    {27'b0, 1'b1, 4'((1 << sz) - 1)});
                chk("R1/R2 flush data", wr_data & lane_mask(wr_strb), v[31:0]);
            end
        end

        // R5: two 16-bit pixels in one word
        cfg_fmt = 4'd7; cfg_alpha_en = 1'b1; cfg_alpha_inv = 1'b0;
        drive(32'h00FF0000, 1'b0);
        chk("R5 first half no write", {31'b0, wr_valid}, 32'h0);
        drive(32'h000000FF, 1'b1);
        chk("R5 pair word", wr_data, 32'h001FF800);
        chk("R5 pair strb", {27'b0, wr_valid, wr_strb}, 32'h1F);
        step();
        chk("R5 no flush when aligned", {30'b0, wr_valid, pix_ready}, 32'h1);

        // R6: four 24-bit pixels over three words
        cfg_fmt = 4'd9;
        drive(32'h00112233, 1'b0);
        chk("R6 p0 no write", {31'b0, wr_valid}, 32'h0);
        drive(32'h00445566, 1'b0);
        chk("R6 word0", wr_data, 32'h66112233);
        drive(32'h00778899, 1'b0);
        chk("R6 word1", wr_data, 32'h88994455);
        drive(32'h00AABBCC, 1'b1);
        chk("R6 word2", wr_data, 32'hAABBCC77);
        chk("R6 word2 valid", {31'b0, wr_valid}, 32'h1);
        step();
        chk("R6 no flush", {31'b0, wr_valid}, 32'h0);

        // R9: partial 24-bit line, input held off during flush
        drive(32'h00112233, 1'b0);
        drive(32'h00445566, 1'b1);
        chk("R9 full word first", wr_data, 32'h66112233);
        chk("R9 ready low in flush", {31'b0, pix_ready}, 32'h0);
        drive(32'h00DDEEFF, 1'b1);
        chk("R9 partial strb", {27'b0, wr_valid, wr_strb}, 32'h13);
        chk("R9 partial data", wr_data & 32'h0000FFFF, 32'h00004455);
        step();
        chk("R9 offered pixel not taken a", {30'b0, wr_valid, pix_ready}, 32'h1);
        step();
        chk("R9 offered pixel not taken b", {31'b0, wr_valid}, 32'h0);

        // R8: mask on full words and on flushes
        cfg_fmt = 4'd13; cfg_byte_en = 4'b0101;
        drive(32'h11223344, 1'b1);
        chk("R8 full word strb masked", {27'b0, wr_valid, wr_strb}, 32'h15);
        cfg_fmt = 4'd7; cfg_byte_en = 4'b1110;
        drive(32'h00FFFFFF, 1'b1);
        step();
        chk("R8/R9 flush strb masked", {27'b0, wr_valid, wr_strb}, 32'h12);
        cfg_byte_en = 4'hF;

        // R11: no input, no write
        cfg_fmt = 4'd13;
        step();
        step();
        chk("R11 idle no write", {27'b0, wr_valid, wr_strb}, 32'h0);

        // R10: unlisted code
        cfg_fmt = 4'd5;
        drive(32'h12345678, 1'b1);
        chk("R10 bad code no write, err", {30'b0, wr_valid, fmt_err}, 32'h1);
        step();
        chk("R10 bad code no later write", {31'b0, wr_valid}, 32'h0);
        cfg_fmt = 4'd10;
        drive(32'h12345678, 1'b1);
        chk("R10 code 10 no write", {31'b0, wr_valid}, 32'h0);
        cfg_fmt = 4'd13; cfg_alpha_en = 1'b1; cfg_alpha_inv = 1'b0;
        drive(32'h12345678, 1'b1);
        chk("R10 err sticky, valid code works", {30'b0, wr_valid, fmt_err}, 32'h3);
        chk("R10 data after error", wr_data, 32'h12345678);

        // R12: reset clears the error and pending bytes
        cfg_fmt = 4'd9;
        drive(32'h00AABBCC, 1'b0);
        rst_n = 1'b0;
        step();
        chk("R12 reset clears err", {29'b0, wr_valid, fmt_err, pix_ready}, 32'h1);
        rst_n = 1'b1;
        cfg_fmt = 4'd13;
        drive(32'h01020304, 1'b1);
        chk("R12 nothing pending after reset", wr_data, 32'h01020304);

        report();
    end
endmodule